// File: doc/BRIEF.md
# Glitch-Free Output Clock Stop and Power-Down Sequencer

This block sits between two free-running source clocks and the output pads of a clock generator. One source carries the frequency-modulated (spread) clock, the other the unmodulated reference clock. The block turns each of them on and off without runt pulses. It acts on an asynchronous, active-low power-down pin and on one enable bit per output from the register bank. A control clock runs the sequencing logic. Every output has its own gate. The gate is retimed first on the rising edge and then on the falling edge of that output's own source clock, so the gate only opens or closes while the source is low.

While power-down is asserted, both outputs are held low and a power-down request goes to the PLL. A register bit picks the pad behaviour during power-down: tri-state (output enable dropped) or actively driven low. When the pin is released, the block holds the outputs stopped for a stability interval. The interval ends when a programmable counter reaches its limit or when a synchronised "PLL locked" flag arrives, whichever comes first. After that, only the outputs whose enable bit is set start running. An output stopped by its enable bit is always driven low. A separate bit turns frequency modulation on or off. The resulting request only reaches the modulator while clocks are live, and it never affects the reference path.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst` is high, `pll_pd` and `clocks_live` are 0, `out_spread` and `out_ref` are 0, and both output enables are 1.
- R2: While `pwrdn_n` is held low, within 10 control cycles `pll_pd` becomes 1, `clocks_live` becomes 0, and both clock outputs stay low with no rising edge.
- R3: Every high pulse on `out_spread` and `out_ref` lasts exactly one high phase of its source clock. No shortened pulse appears at any start or stop.
- R4: During power-down, `pd_drive_low`=0 drives both output enables to 0 (tri-state), and `pd_drive_low`=1 keeps both at 1 with the outputs low.
- R5: An enable bit at 0 stops only its own output. That output is low with its output enable at 1, whatever `pd_drive_low` is, and the other output keeps toggling.
- R6: Count control clock edges from the first edge at which `pll_pd` reads 0 after a release, with `pll_lock` low. `clocks_live` reads 1 after exactly max(`stable_len`,1) of these edges.
- R7: If `pll_lock` is 1 when power-down is released, `clocks_live` rises within 3 control edges after `pll_pd` falls, even with a large `stable_len`.
- R8: `spread_mod` is 1 only while `clocks_live` is 1 and `spread_on` is 1. It reads 0 while `spread_on` is 0 and during power-down.
- R9: An output whose enable bit is 0 when power-down is released stays low after `clocks_live` rises, and it starts only when its bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock for sequencing |
| rst | input | 1 | Synchronous active-high reset |
| clk_spread | input | 1 | Modulated source clock |
| clk_ref | input | 1 | Unmodulated reference source clock |
| pwrdn_n | input | 1 | Asynchronous active-low power-down pin |
| en_spread | input | 1 | Register bit: 1 lets the spread output run |
| en_ref | input | 1 | Register bit: 1 lets the reference output run |
| pd_drive_low | input | 1 | Register bit: power-down pads 0 = tri-state, 1 = driven low |
| spread_on | input | 1 | Register bit: 1 requests frequency modulation |
| pll_lock | input | 1 | Asynchronous PLL-stable flag |
| stable_len | input | CNT_W | Stability wait in control cycles (0 acts as 1) |
| out_spread | output | 1 | Gated spread clock |
| out_ref | output | 1 | Gated reference clock |
| oe_spread | output | 1 | Pad enable for the spread output |
| oe_ref | output | 1 | Pad enable for the reference output |
| pll_pd | output | 1 | Power-down request to PLL and VCO |
| clocks_live | output | 1 | Stability wait done and power-down released |
| spread_mod | output | 1 | Modulation request to the modulator |

## Verification
The stability wait is swept over limits 0 to 10 and 200, with the lock flag low, and the release edge is counted exactly. A lock-driven release then shows that the flag overrides a long counter. Power-down is applied once in each pad mode, which separates tri-state from drive-low on the enable pins. The enable bits are walked through both-on, reference-off and spread-off, including a release with one bit already clear, which shows that one output can be stopped on its own. The two source clocks have periods that are not multiples of each other. A pulse-width monitor runs the whole time on both outputs, so a gate that switches outside the low phase shows up as a short pulse.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic [1:0] {
    ST_PD   = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } seq_st_t;

  localparam int unsigned N_OUT  = 2;
  localparam int unsigned IDX_SP = 0;
  localparam int unsigned IDX_RF = 1;
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clkstop_seq.sv
module clkstop_seq
  import clkstop_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pd_s,
  input  logic             lock_s,
  input  logic [CNT_W-1:0] stable_len,
  input  logic [N_OUT-1:0] en,
  input  logic             drive_low,
  input  logic             spread_on,
  output logic             pll_pd,
  output logic             live,
  output logic [N_OUT-1:0] req,
  output logic             oe_req,
  output logic             spread_mod
);
  seq_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_nx;
  logic             done;

  assign cnt_nx = {1'b0, cnt} + 1'b1;
  assign done   = cnt_nx >= {1'b0, stable_len};

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_WAIT;
      cnt        <= '0;
      spread_mod <= 1'b0;
    end else begin
      unique case (st)
        ST_PD: if (!pd_s) begin
          st  <= ST_WAIT;
          cnt <= '0;
        end
        ST_WAIT: begin
          if (pd_s)                st  <= ST_PD;
          else if (lock_s || done) st  <= ST_RUN;
          else                     cnt <= cnt_nx[CNT_W-1:0];
        end
        default: if (pd_s) st <= ST_PD;
      endcase
      spread_mod <= spread_on && (st == ST_RUN) && !pd_s;
    end
  end

  assign pll_pd = (st == ST_PD);
  assign live   = (st == ST_RUN);
  assign req    = live ? en : '0;
  assign oe_req = !((st == ST_PD) && !drive_low);

  // R2: a synchronised power-down always ends the live state next cycle
  p_pd_stops_r2: assert property (@(posedge clk) disable iff (rst)
    pd_s |=> !live);
  // R2: and it always raises the PLL power-down request
  p_pd_raises_r2: assert property (@(posedge clk) disable iff (rst)
    pd_s |=> pll_pd);
  // R6 / R7: clocks go live only after terminal count or lock
  p_wait_release_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(live) |-> ($past(lock_s) || $past(done)));
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate (
  input  logic src_clk,
  input  logic rst,
  input  logic req,
  input  logic oe_req,
  output logic clk_out,
  output logic oe
);
  logic req_m, oe_m, gate;

  // first stage on the rising edge of the source
  always_ff @(posedge src_clk) begin
    if (rst) begin
      req_m <= 1'b0;
      oe_m  <= 1'b1;
    end else begin
      req_m <= req;
      oe_m  <= oe_req;
    end
  end

  // final stage on the falling edge: the gate only moves while src is low
  always_ff @(negedge src_clk) begin
    if (rst) begin
      gate <= 1'b0;
      oe   <= 1'b1;
    end else begin
      gate <= req_m;
      oe   <= oe_m;
    end
  end

  assign clk_out = src_clk & gate;

  // R4: the pad is never tri-stated while the gate passes pulses
  p_oe_with_gate_r4: assert property (@(negedge src_clk) disable iff (rst)
    gate |-> oe);
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_spread,
  input  logic             clk_ref,
  input  logic             pwrdn_n,
  input  logic             en_spread,
  input  logic             en_ref,
  input  logic             pd_drive_low,
  input  logic             spread_on,
  input  logic             pll_lock,
  input  logic [CNT_W-1:0] stable_len,
  output logic             out_spread,
  output logic             out_ref,
  output logic             oe_spread,
  output logic             oe_ref,
  output logic             pll_pd,
  output logic             clocks_live,
  output logic             spread_mod
);
  logic             pd_s, lock_s, oe_req;
  logic [N_OUT-1:0] req, src_v, gclk, goe, en_v;

  clkstop_sync #(.W(1), .STAGES(SYNC_STAGES)) u_pd_sync (
    .clk(clk), .rst(rst), .d(~pwrdn_n), .q(pd_s));

  clkstop_sync #(.W(1), .STAGES(SYNC_STAGES)) u_lock_sync (
    .clk(clk), .rst(rst), .d(pll_lock), .q(lock_s));

  assign en_v[IDX_SP]  = en_spread;
  assign en_v[IDX_RF]  = en_ref;
  assign src_v[IDX_SP] = clk_spread;
  assign src_v[IDX_RF] = clk_ref;

  clkstop_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .pd_s(pd_s), .lock_s(lock_s),
    .stable_len(stable_len), .en(en_v), .drive_low(pd_drive_low),
    .spread_on(spread_on), .pll_pd(pll_pd), .live(clocks_live),
    .req(req), .oe_req(oe_req), .spread_mod(spread_mod));

  for (genvar g = 0; g < int'(N_OUT); g++) begin : g_out
    clkstop_gate u_gate (
      .src_clk(src_v[g]), .rst(rst), .req(req[g]), .oe_req(oe_req),
      .clk_out(gclk[g]), .oe(goe[g]));
  end

  assign out_spread = gclk[IDX_SP];
  assign out_ref    = gclk[IDX_RF];
  assign oe_spread  = goe[IDX_SP];
  assign oe_ref     = goe[IDX_RF];
endmodule

// File: tb/sim_clkstop_ctrl.sv
`timescale 1ns/1ps
module sim_clkstop_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SP_HALF    = 7;
  localparam int RF_HALF    = 12;
  localparam int CNT_W      = 16;

  logic clk = 0, clk_spread = 0, clk_ref = 0;
  logic rst = 1, pwrdn_n = 1, en_spread = 1, en_ref = 1;
  logic pd_drive_low = 0, spread_on = 1, pll_lock = 0;
  logic [CNT_W-1:0] stable_len = 16'd4;
  logic out_spread, out_ref, oe_spread, oe_ref, pll_pd, clocks_live, spread_mod;

  int checks = 0, failures = 0;
  int n_sp = 0, n_rf = 0, runts = 0;
  time t_sp = 0, t_rf = 0;
  bit  done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(SP_HALF) clk_spread = ~clk_spread;
  always #(RF_HALF) clk_ref = ~clk_ref;

  clkstop_ctrl #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .clk_spread(clk_spread), .clk_ref(clk_ref),
    .pwrdn_n(pwrdn_n), .en_spread(en_spread), .en_ref(en_ref),
    .pd_drive_low(pd_drive_low), .spread_on(spread_on), .pll_lock(pll_lock),
    .stable_len(stable_len), .out_spread(out_spread), .out_ref(out_ref),
    .oe_spread(oe_spread), .oe_ref(oe_ref), .pll_pd(pll_pd),
    .clocks_live(clocks_live), .spread_mod(spread_mod));

  // pulse monitors (R3)
  always @(posedge out_spread) begin n_sp++; t_sp = $time; end
  always @(posedge out_ref)    begin n_rf++; t_rf = $time; end
  always @(negedge out_spread) if ($time - t_sp != SP_HALF) runts++;
  always @(negedge out_ref)    if ($time - t_rf != RF_HALF) runts++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic window(output int sp, output int rf);
    n_sp = 0; n_rf = 0;
    cyc(40);
    sp = n_sp; rf = n_rf;
  endtask

  // power down, release at a falling control edge, count edges to live
  task automatic pd_cycle(output int n);
    @(negedge clk); pwrdn_n = 0;
    cyc(10);
    @(negedge clk); pwrdn_n = 1;
    n = 0;
    for (int i = 0; i < 20 && pll_pd; i++) cyc(1);
    while (!clocks_live && n < 1000) begin cyc(1); n++; end
  endtask

  initial begin
    int sp, rf, n, expn;
    cyc(10);
    chk(pll_pd == 0 && clocks_live == 0, "R1", "pd/live in reset", {pll_pd, clocks_live}, 0);
    chk(out_spread == 0 && out_ref == 0, "R1", "outputs in reset", {out_spread, out_ref}, 0);
    chk(oe_spread && oe_ref, "R1", "oe in reset", {oe_spread, oe_ref}, 3);
    @(negedge clk); rst = 0;
    cyc(20);

    // R6: sweep the stability limit
    for (int len = 0; len <= 10; len++) begin
      stable_len = 16'(len);
      pd_cycle(n);
      expn = (len == 0) ? 1 : len;
      chk(n == expn, "R6", $sformatf("wait cycles len=%0d", len), n, expn);
    end
    stable_len = 16'd200;
    pd_cycle(n);
    chk(n == 200, "R6", "wait cycles len=200", n, 200);
    cyc(10);
    window(sp, rf);
    chk(sp >= 25 && rf >= 14, "R5", "both running", sp + rf, 40);

    // R7: lock flag overrides long counter
    pll_lock = 1;
    pd_cycle(n);
    chk(n >= 1 && n <= 3, "R7", "lock release cycles", n, 1);
    pll_lock = 0;
    cyc(10);

    // R8 while live
    chk(spread_mod == 1, "R8", "modulation on while live", spread_mod, 1);
    @(negedge clk); spread_on = 0; cyc(3);
    chk(spread_mod == 0, "R8", "modulation off by bit", spread_mod, 0);
    @(negedge clk); spread_on = 1; cyc(3);

    // R2 / R4: power-down, tri-state mode
    stable_len = 16'd10;
    @(negedge clk); pd_drive_low = 0; pwrdn_n = 0;
    cyc(10);
    chk(pll_pd == 1 && clocks_live == 0, "R2", "pd state", {pll_pd, clocks_live}, 2);
    chk(spread_mod == 0, "R8", "modulation off in pd", spread_mod, 0);
    window(sp, rf);
    chk(sp == 0 && rf == 0, "R2", "edges in pd", sp + rf, 0);
    chk(out_spread == 0 && out_ref == 0, "R2", "outputs low in pd", {out_spread, out_ref}, 0);
    chk(oe_spread == 0 && oe_ref == 0, "R4", "tri-state oe", {oe_spread, oe_ref}, 0);
    @(negedge clk); pd_drive_low = 1; cyc(10);
    chk(oe_spread && oe_ref, "R4", "drive-low oe", {oe_spread, oe_ref}, 3);
    chk(out_spread == 0 && out_ref == 0, "R4", "drive-low level", {out_spread, out_ref}, 0);

    // R9: release with reference disabled
    @(negedge clk); pd_drive_low = 0; en_ref = 0; pwrdn_n = 1;
    cyc(30);
    chk(clocks_live == 1, "R9", "live after release", clocks_live, 1);
    window(sp, rf);
    chk(sp >= 25 && rf == 0, "R9", "ref stays stopped", rf, 0);
    chk(oe_ref == 1 && out_ref == 0, "R5", "stopped ref driven low", {oe_ref, out_ref}, 2);
    @(negedge clk); en_ref = 1; cyc(5);
    window(sp, rf);
    chk(rf >= 14, "R9", "ref starts when enabled", rf, 16);

    // R5: spread stopped alone
    @(negedge clk); en_spread = 0; cyc(5);
    window(sp, rf);
    chk(sp == 0 && rf >= 14, "R5", "spread stopped ref runs", sp, 0);
    chk(oe_spread == 1 && out_spread == 0, "R5", "stopped spread driven low",
        {oe_spread, out_spread}, 2);
    @(negedge clk); en_spread = 1; cyc(5);
    window(sp, rf);
    chk(sp >= 25, "R5", "spread restarts", sp, 28);

    chk(runts == 0, "R3", "short pulses", runts, 0);
    if (!done_flag) begin
      done_flag = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      done_flag = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule